// File: doc/BRIEF.md
# Two-Beam Wrong-Way Detector

This block watches two light-beam sensors mounted along a one-way lane and raises an alarm when a vehicle travels the wrong way. The sensors, called A (upstream) and B (downstream), are closer together than a car is long. A car going the permitted way breaks A first, then both beams, then only B, and finally neither. A car going the wrong way breaks B first.

Direction is found by sampling the level of A while B is broken. This works like a transparent data latch: A is the data and B is the gate. Both raw beam signals pass through a synchronizer chain of at least two flops. A capture stage then registers A on every clock cycle in which B is broken. A small state machine turns the captured value into a decision and holds that decision until both beams are clear. The alarm output is registered. A synchronous reset puts the machine in its idle state and clears the alarm.

The state machine has three states. IDLE means no decision has been made. PASS means a permitted passage is in progress. WRONG means a wrong-way passage is in progress, and the alarm is high. The transitions are:
- IDLE→WRONG (reverse entry): B is seen broken while the sample of A is low.
- IDLE→PASS (forward entry): B is seen broken while the sample of A is high.
- PASS→IDLE (forward exit) and WRONG→IDLE (reverse exit): both synchronized beams read unbroken.

Top module: `wrong_way_detector`

## Requirements
- R1: While reset is high, and on the first clock edge after reset is released, the alarm output is low.
- R2: A permitted passage never raises the alarm at any step of its sequence: A alone, then A and B, then B alone, then neither.
- R3: When B breaks while A is unbroken, the alarm rises on the fourth rising clock edge after the raw B change, and not earlier.
- R4: Once the alarm is high, it stays high as long as either beam is broken, including when A breaks later in the same passage.
- R5: The alarm falls on the third rising clock edge after both raw beams become unbroken.
- R6: When A is permanently broken (its light source has failed), activity on B never raises the alarm.
- R7: When B becomes permanently broken, the alarm is high if A was unbroken at that moment and stays low if A was broken at that moment.
- R8: Breaking and restoring A alone, with B never broken, does not raise the alarm.
- R9: Asserting reset while the alarm is high clears the alarm on the next rising clock edge.

A beam input reads 1 when the beam is broken. The alarm reads 1 when active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| beam_a_raw | input | 1 | Upstream sensor, 1 = beam broken, asynchronous |
| beam_b_raw | input | 1 | Downstream sensor, 1 = beam broken, asynchronous |
| alarm_o | output | 1 | Registered wrong-way alarm, 1 = active |

## Verification
A wrong state shows up directly at the alarm pin. If the machine lands in WRONG, the alarm rises no later than the cycle after the decision. If it lands in PASS instead, a reverse entry stays silent for the whole passage. A stale captured value of A can only reach the alarm on the cycle after B is registered as broken. A state that fails to leave WRONG keeps the alarm high beyond the third edge after both beams clear. The bench checks the alarm at the exact edge where each decision or release should take effect, and again after the inputs have settled.

// File: rtl/ww_pkg.sv
package ww_pkg;

    // Decision states of the direction machine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_WRONG = 2'd2
    } ww_state_e;

    // A synchronizer shorter than this cannot settle a metastable flop
    localparam int unsigned WW_MIN_SYNC = 2;

endpackage

// File: rtl/ww_sync.sv
module ww_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    generate
        genvar gi;
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) chain_q[gi] <= 1'b0;
                    else     chain_q[gi] <= d_i;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) chain_q[gi] <= 1'b0;
                    else     chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[LAST];

endmodule

// File: rtl/ww_capture.sv
module ww_capture (
    input  logic clk,
    input  logic rst,
    input  logic data_i,     // synchronized A level
    input  logic gate_i,     // synchronized B level, acts as the latch enable
    output logic sample_o,   // last A value taken while gate was high
    output logic valid_o     // gate level aligned with sample_o
);
    logic sample_q;
    logic valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= 1'b1;   // safe value: a high A sample means permitted direction
            valid_q  <= 1'b0;
        end else begin
            valid_q <= gate_i;
            if (gate_i) sample_q <= data_i;
        end
    end

    assign sample_o = sample_q;
    assign valid_o  = valid_q;

endmodule

// File: rtl/ww_fsm.sv
module ww_fsm
    import ww_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_lvl_i,
    input  logic b_lvl_i,
    input  logic smp_valid_i,
    input  logic smp_a_i,
    output logic alarm_o
);
    ww_state_e state_q;
    ww_state_e state_d;
    logic      alarm_q;
    logic      both_clear;

    assign both_clear = !a_lvl_i && !b_lvl_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (smp_valid_i) begin
                    if (smp_a_i) state_d = ST_PASS;    // forward entry
                    else         state_d = ST_WRONG;   // reverse entry
                end
            end
            ST_PASS: begin
                if (both_clear) state_d = ST_IDLE;     // forward exit
            end
            ST_WRONG: begin
                if (both_clear) state_d = ST_IDLE;     // reverse exit
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) alarm_q <= 1'b0;
        else     alarm_q <= (state_d == ST_WRONG);
    end

    assign alarm_o = alarm_q;

endmodule

// File: rtl/wrong_way_detector.sv
module wrong_way_detector
    import ww_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic beam_a_raw,
    input  logic beam_b_raw,
    output logic alarm_o
);
    localparam int unsigned STAGES_USED =
        (SYNC_STAGES < WW_MIN_SYNC) ? WW_MIN_SYNC : SYNC_STAGES;

    logic a_lvl;
    logic b_lvl;
    logic smp_a;
    logic smp_valid;

    ww_sync #(.STAGES(STAGES_USED)) u_sync_a (
        .clk (clk),
        .rst (rst),
        .d_i (beam_a_raw),
        .q_o (a_lvl)
    );

    ww_sync #(.STAGES(STAGES_USED)) u_sync_b (
        .clk (clk),
        .rst (rst),
        .d_i (beam_b_raw),
        .q_o (b_lvl)
    );

    ww_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .data_i   (a_lvl),
        .gate_i   (b_lvl),
        .sample_o (smp_a),
        .valid_o  (smp_valid)
    );

    ww_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .a_lvl_i     (a_lvl),
        .b_lvl_i     (b_lvl),
        .smp_valid_i (smp_valid),
        .smp_a_i     (smp_a),
        .alarm_o     (alarm_o)
    );

endmodule

// File: rtl/wrong_way_detector_chk.sv
module wrong_way_detector_chk (
    input logic clk,
    input logic rst,
    input logic a_lvl,
    input logic b_lvl,
    input logic smp_valid,
    input logic smp_a,
    input logic alarm_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !alarm_o);

    // R3
    alarm_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_o) |-> ($past(smp_valid) && !$past(smp_a)));

    // R4
    alarm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_o && (a_lvl || b_lvl)) |=> alarm_o);

    // R5
    alarm_release_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_o && !a_lvl && !b_lvl) |=> !alarm_o);

    // R6
    capture_follow_chk: assert property (@(posedge clk) disable iff (rst)
        b_lvl |=> (smp_valid && (smp_a == $past(a_lvl))));

    // R8
    no_gate_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !$rose(alarm_o));

endmodule

bind wrong_way_detector wrong_way_detector_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_lvl     (a_lvl),
    .b_lvl     (b_lvl),
    .smp_valid (smp_valid),
    .smp_a     (smp_a),
    .alarm_o   (alarm_o)
);

// File: tb/wrong_way_detector_bench.sv
module wrong_way_detector_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic beam_a_raw = 1'b0;
    logic beam_b_raw = 1'b0;
    logic alarm_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    wrong_way_detector u_wrong_way_detector (
        .clk        (clk),
        .rst        (rst),
        .beam_a_raw (beam_a_raw),
        .beam_b_raw (beam_b_raw),
        .alarm_o    (alarm_o)
    );

    // Driver: apply levels on a falling edge, count rising edges, then queue expected alarm
    task automatic drive(input logic a, input logic b, input int edges,
                         input logic exp, input string tag);
        @(negedge clk);
        beam_a_raw = a;
        beam_b_raw = b;
        repeat (edges) @(posedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic drive_rst(input logic r, input int edges,
                             input logic exp, input string tag);
        @(negedge clk);
        rst = r;
        repeat (edges) @(posedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare on the falling edge following each queued item
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (alarm_o !== e) begin
                    bad++;
                    $display("FAIL %s: alarm actual=%b expected=%b", t, alarm_o, e);
                end
            end
        end
    end

    task automatic settle_all;
        drive(1'b0, 1'b0, 6, 1'b0, "settle");
    endtask

    initial begin
        // R1: reset state and first edge after release
        drive_rst(1'b1, 3, 1'b0, "R1 in reset");
        drive_rst(1'b0, 1, 1'b0, "R1 after release");

        // R2: permitted passage, every step
        drive(1'b1, 1'b0, 6, 1'b0, "R2 A only");
        drive(1'b1, 1'b1, 6, 1'b0, "R2 A and B");
        drive(1'b0, 1'b1, 6, 1'b0, "R2 B only");
        drive(1'b0, 1'b0, 6, 1'b0, "R2 clear");

        // R3: reverse entry, exact latency
        drive(1'b0, 1'b1, 3, 1'b0, "R3 edge three");
        drive(1'b0, 1'b1, 1, 1'b1, "R3 edge four");
        // R4: alarm holds as A breaks and B clears
        drive(1'b1, 1'b1, 6, 1'b1, "R4 both broken");
        drive(1'b1, 1'b0, 6, 1'b1, "R4 A only");
        // R5: release latency
        drive(1'b0, 1'b0, 2, 1'b1, "R5 edge two");
        drive(1'b0, 1'b0, 1, 1'b0, "R5 edge three");
        settle_all();

        // R8: A alone toggles
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 1'b0, 5, 1'b0, "R8 A broken");
            drive(1'b0, 1'b0, 5, 1'b0, "R8 A restored");
        end

        // R6: A stuck broken, B pulses in both orders
        drive(1'b1, 1'b0, 6, 1'b0, "R6 A stuck");
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 1'b1, 6, 1'b0, "R6 B broken");
            drive(1'b1, 1'b0, 6, 1'b0, "R6 B restored");
        end
        settle_all();

        // R7: B stuck with A clear -> alarm; stays
        drive(1'b0, 1'b1, 6, 1'b1, "R7 B stuck, A clear");
        drive(1'b1, 1'b1, 6, 1'b1, "R7 A later broken");
        drive(1'b0, 1'b1, 6, 1'b1, "R7 A restored");

        // R9: reset while alarm high
        drive_rst(1'b1, 1, 1'b0, "R9 reset clears");
        drive(1'b0, 1'b0, 1, 1'b0, "R9 held in reset");
        drive_rst(1'b0, 6, 1'b0, "R9 released");

        // R7: B stuck with A broken -> no alarm
        drive(1'b1, 1'b0, 6, 1'b0, "R7 A broken first");
        drive(1'b1, 1'b1, 6, 1'b0, "R7 B stuck, A broken");
        drive(1'b0, 1'b1, 6, 1'b0, "R7 A restored, B stuck");
        settle_all();

        // R2: second permitted passage after all of the above
        drive(1'b1, 1'b0, 4, 1'b0, "R2 again A");
        drive(1'b1, 1'b1, 4, 1'b0, "R2 again AB");
        drive(1'b0, 1'b1, 4, 1'b0, "R2 again B");
        drive(1'b0, 1'b0, 4, 1'b0, "R2 again clear");

        repeat (4) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule